// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Entry Controller

This block decides when a small 16-bit processor enters an interrupt handler and where it goes. It watches two active-low hardware request lines and a two-bit software request code that lives in the 8-bit processor status word. It acts only when the core signals that an instruction has just completed. When it accepts a request, it issues a one-cycle take pulse and the handler start address. It also returns an updated status word for the core to write back, and it keeps a copy of the return PC and of the status word as they stood before entry.

The status word layout is fixed. Bit 0 is Zero, bit 1 is Carry, bit 2 is Sign, and bit 3 is the global interrupt enable. Bits 5:4 hold the software request code, and bits 7:6 hold the cause code that is recorded on entry. The hardware lines pass through a two-stage synchroniser before they are used. Hardware line 1 has the highest priority, then hardware line 0, then a software request. Line 0 and software requests share the same vector. The handler tells them apart by reading the cause field.

Top module: `irq_entry_ctrl`

## Requirements
- R1: After synchronous reset, take_irq, psr_wr, vec_addr, psr_out, saved_pc and saved_psr are all zero.
- R2: A request is accepted only on a clock edge where instr_done is 1. Without that strobe, take_irq stays 0.
- R3: A request is accepted only when bit 3 (enable) of psr_in is 1.
- R4: When only hardware line 0 is low (irq_n[0]=0), the vector is 0x0002 and the cause field psr_out[7:6] is 01.
- R5: When hardware line 1 is low, the vector is 0x0004 and the cause is 10. This applies even when line 0 is also low or a software code is set.
- R6: A nonzero psr_in[5:4] with both hardware lines high gives vector 0x0002 and cause 11. Any low hardware line takes priority over it.
- R7: take_irq and psr_wr are high together for exactly one cycle. psr_out equals psr_in with bit 3 cleared and bits 7:6 set to the cause. Bits 5:0 other than bit 3, including the software code, are copied unchanged.
- R8: On acceptance, saved_pc takes the value of cur_pc and saved_psr takes the value of psr_in, both as sampled on the accepting edge.
- R9: A hardware line that goes low just before clock edge k can be accepted no earlier than edge k+2.
- R10: No request is accepted on the edge directly after an accepting edge, even if instr_done and enable are still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_n | input | 2 | Active-low hardware interrupt lines, asynchronous |
| instr_done | input | 1 | Current instruction has completed this cycle |
| cur_pc | input | 16 | PC to return to after the handler |
| psr_in | input | 8 | Current processor status word |
| take_irq | output | 1 | One-cycle pulse: enter handler |
| vec_addr | output | 16 | Handler start address, held until the next entry |
| psr_wr | output | 1 | Write strobe for psr_out |
| psr_out | output | 8 | Status word to load on entry |
| saved_pc | output | 16 | Captured return PC |
| saved_psr | output | 8 | Captured status word from before entry |

## Verification
The bench sweeps every combination of the two line levels, the four software codes, the enable bit and the completion strobe. It computes the expected vector, cause and status word for each one. The sweep exposes a wrong priority order, for example line 0 or software winning over line 1, because the result would be the wrong vector or cause. It also catches a status update that drops the software code or leaves enable set. A separate sequence holds a line low with the strobe held high. It checks that the first acceptance comes on the third edge, which catches a missing synchroniser stage. It then checks that the edge after an acceptance is refused, which catches a design that re-enters before the core has written the cleared enable back.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int PSR_W       = 8;
  localparam int PSR_Z       = 0;
  localparam int PSR_C       = 1;
  localparam int PSR_S       = 2;
  localparam int PSR_IE      = 3;
  localparam int PSR_SWI_LO  = 4;
  localparam int PSR_SWI_HI  = 5;
  localparam int PSR_CSE_LO  = 6;
  localparam int PSR_CSE_HI  = 7;
  localparam int NUM_HW      = 2;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_HW0  = 2'b01,
    CAUSE_HW1  = 2'b10,
    CAUSE_SW   = 2'b11
  } cause_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] IDLE = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{IDLE}};
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_entry_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] VEC_HW0 = 16'h0002,
  parameter logic [ADDR_W-1:0] VEC_HW1 = 16'h0004,
  parameter logic [ADDR_W-1:0] VEC_SW  = 16'h0002
) (
  input  logic [NUM_HW-1:0] hw_act,
  input  logic [1:0]        swi_code,
  output logic              req,
  output cause_e            cause,
  output logic [ADDR_W-1:0] vec
);
  always_comb begin
    req   = 1'b1;
    cause = CAUSE_NONE;
    vec   = '0;
    if (hw_act[1]) begin
      cause = CAUSE_HW1;
      vec   = VEC_HW1;
    end else if (hw_act[0]) begin
      cause = CAUSE_HW0;
      vec   = VEC_HW0;
    end else if (swi_code != 2'b00) begin
      cause = CAUSE_SW;
      vec   = VEC_SW;
    end else begin
      req   = 1'b0;
    end
  end
endmodule

// File: rtl/irq_state_save.sv
module irq_state_save #(
  parameter int ADDR_W = 16,
  parameter int PSR_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [PSR_W-1:0]  psr_in,
  output logic [ADDR_W-1:0] pc_q,
  output logic [PSR_W-1:0]  psr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      psr_q <= '0;
    end else if (capture) begin
      pc_q  <= pc_in;
      psr_q <= psr_in;
    end
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] VEC_HW0     = 16'h0002,
  parameter logic [ADDR_W-1:0] VEC_HW1     = 16'h0004,
  parameter logic [ADDR_W-1:0] VEC_SW      = 16'h0002
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        irq_n,
  input  logic              instr_done,
  input  logic [15:0]       cur_pc,
  input  logic [7:0]        psr_in,
  output logic              take_irq,
  output logic [15:0]       vec_addr,
  output logic              psr_wr,
  output logic [7:0]        psr_out,
  output logic [15:0]       saved_pc,
  output logic [7:0]        saved_psr
);
  logic [NUM_HW-1:0] irq_n_sync;
  logic              arb_req;
  cause_e            arb_cause;
  logic [ADDR_W-1:0] arb_vec;
  logic              accept;
  logic [PSR_W-1:0]  next_psr;

  irq_sync #(.WIDTH(NUM_HW), .STAGES(SYNC_STAGES), .IDLE('1)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (irq_n),
    .q   (irq_n_sync)
  );

  irq_arbiter #(
    .ADDR_W(ADDR_W), .VEC_HW0(VEC_HW0), .VEC_HW1(VEC_HW1), .VEC_SW(VEC_SW)
  ) arb_i (
    .hw_act   (~irq_n_sync),
    .swi_code (psr_in[PSR_SWI_HI:PSR_SWI_LO]),
    .req      (arb_req),
    .cause    (arb_cause),
    .vec      (arb_vec)
  );

  assign accept = instr_done && psr_in[PSR_IE] && arb_req && !take_irq;

  always_comb begin
    next_psr                        = psr_in;
    next_psr[PSR_IE]                = 1'b0;
    next_psr[PSR_CSE_HI:PSR_CSE_LO] = arb_cause;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      take_irq <= 1'b0;
      psr_wr   <= 1'b0;
      vec_addr <= '0;
      psr_out  <= '0;
    end else begin
      take_irq <= accept;
      psr_wr   <= accept;
      if (accept) begin
        vec_addr <= arb_vec;
        psr_out  <= next_psr;
      end
    end
  end

  irq_state_save #(.ADDR_W(ADDR_W), .PSR_W(PSR_W)) save_i (
    .clk     (clk),
    .rst     (rst),
    .capture (accept),
    .pc_in   (cur_pc),
    .psr_in  (psr_in),
    .pc_q    (saved_pc),
    .psr_q   (saved_psr)
  );
endmodule

// File: rtl/irq_entry_ctrl_chk.sv
module irq_entry_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        instr_done,
  input logic [15:0] cur_pc,
  input logic [7:0]  psr_in,
  input logic        take_irq,
  input logic [15:0] vec_addr,
  input logic        psr_wr,
  input logic [7:0]  psr_out,
  input logic [15:0] saved_pc,
  input logic [7:0]  saved_psr
);
  a_r2_needs_done: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> $past(instr_done));
  a_r3_needs_enable: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> $past(psr_in[3]));
  a_r5_line1_vector: assert property (@(posedge clk) disable iff (rst)
    (take_irq && psr_out[7:6] == 2'b10) |-> vec_addr == 16'h0004);
  a_r7_enable_cleared: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> (!psr_out[3] && psr_wr));
  a_r8_pc_captured: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> (saved_pc == $past(cur_pc) && saved_psr == $past(psr_in)));
  a_r10_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    take_irq |=> !take_irq);
endmodule

bind irq_entry_ctrl irq_entry_ctrl_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .instr_done (instr_done),
  .cur_pc     (cur_pc),
  .psr_in     (psr_in),
  .take_irq   (take_irq),
  .vec_addr   (vec_addr),
  .psr_wr     (psr_wr),
  .psr_out    (psr_out),
  .saved_pc   (saved_pc),
  .saved_psr  (saved_psr)
);

// File: tb/irq_entry_ctrl_tb_top.sv
module irq_entry_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  irq_n;
  logic        instr_done;
  logic [15:0] cur_pc;
  logic [7:0]  psr_in;
  logic        take_irq;
  logic [15:0] vec_addr;
  logic        psr_wr;
  logic [7:0]  psr_out;
  logic [15:0] saved_pc;
  logic [7:0]  saved_psr;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_n(irq_n), .instr_done(instr_done),
    .cur_pc(cur_pc), .psr_in(psr_in), .take_irq(take_irq),
    .vec_addr(vec_addr), .psr_wr(psr_wr), .psr_out(psr_out),
    .saved_pc(saved_pc), .saved_psr(saved_psr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; irq_n = 2'b11; instr_done = 1'b0; cur_pc = '0; psr_in = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 take", {31'd0, take_irq}, 32'd0);
    chk("R1 psr_wr", {31'd0, psr_wr}, 32'd0);
    chk("R1 vec", {16'd0, vec_addr}, 32'd0);
    chk("R1 psr_out", {24'd0, psr_out}, 32'd0);
    chk("R1 saved", {saved_pc, 8'd0, saved_psr}, 32'd0);
    rst = 1'b0;

    for (int hw = 0; hw < 4; hw++) begin
      for (int swi = 0; swi < 4; swi++) begin
        for (int ie = 0; ie < 2; ie++) begin
          for (int d = 0; d < 2; d++) begin
            logic [2:0]  flags;
            logic [7:0]  pin;
            logic [15:0] pc;
            logic        exp_take;
            logic [1:0]  exp_cause;
            logic [15:0] exp_vec;
            string       tag;
            flags = 3'(hw * 3 + swi + d);
            pin = {2'(swi ^ hw), 2'(swi), 1'(ie), flags};
            pc = 16'(16'h1000 + hw * 97 + swi * 13 + ie * 5 + d);
            @(negedge clk);
            irq_n = ~2'(hw);
            psr_in = pin;
            instr_done = 1'b0;
            cur_pc = pc;
            repeat (3) @(negedge clk);
            chk("R2 idle without strobe", {31'd0, take_irq}, 32'd0);
            instr_done = 1'(d);
            @(negedge clk);
            instr_done = 1'b0;
            if (hw[1]) begin exp_cause = 2'b10; exp_vec = 16'h0004; end
            else if (hw[0]) begin exp_cause = 2'b01; exp_vec = 16'h0002; end
            else begin exp_cause = 2'b11; exp_vec = 16'h0002; end
            exp_take = (d == 1) && (ie == 1) && (hw != 0 || swi != 0);
            if (d == 0) tag = "R2";
            else if (ie == 0) tag = "R3";
            else if (hw[1]) tag = "R5";
            else if (hw[0]) tag = "R4";
            else tag = "R6";
            chk({tag, " take"}, {31'd0, take_irq}, {31'd0, exp_take});
            chk("R7 psr_wr", {31'd0, psr_wr}, {31'd0, exp_take});
            if (exp_take) begin
              chk({tag, " vector"}, {16'd0, vec_addr}, {16'd0, exp_vec});
              chk({tag, " cause"}, {30'd0, psr_out[7:6]}, {30'd0, exp_cause});
              chk("R7 status body", {24'd0, psr_out}, {24'd0, exp_cause, pin[5:4], 1'b0, pin[2:0]});
              chk("R8 saved pc", {16'd0, saved_pc}, {16'd0, pc});
              chk("R8 saved psr", {24'd0, saved_psr}, {24'd0, pin});
            end
            @(negedge clk);
            chk("R7 one-cycle pulse", {30'd0, take_irq, psr_wr}, 32'd0);
          end
        end
      end
    end

    // R9 latency and R10 refusal after acceptance
    @(negedge clk);
    irq_n = 2'b11; psr_in = 8'h08; instr_done = 1'b1; cur_pc = 16'h2222;
    repeat (4) @(negedge clk);
    chk("R9 idle", {31'd0, take_irq}, 32'd0);
    irq_n = 2'b10;
    @(negedge clk);
    chk("R9 edge k", {31'd0, take_irq}, 32'd0);
    @(negedge clk);
    chk("R9 edge k+1", {31'd0, take_irq}, 32'd0);
    @(negedge clk);
    chk("R9 edge k+2", {31'd0, take_irq}, 32'd1);
    chk("R4 vector", {16'd0, vec_addr}, 32'h0002);
    @(negedge clk);
    chk("R10 refused", {31'd0, take_irq}, 32'd0);
    @(negedge clk);
    chk("R10 next accept", {31'd0, take_irq}, 32'd1);
    instr_done = 1'b0;
    irq_n = 2'b11;
    @(negedge clk);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule